// File: doc/BRIEF.md
# Read Response Generator

This block turns an accepted read request into a read response. A request arrives as one ready/valid transfer that carries the requester's ID, the target's ID, a 2-bit priority, an 8-bit transaction tag and a byte count. The block then drives two output streams that are independent of each other. The header stream carries one 115-bit response header word. The payload stream carries 128-bit data beats, which pass straight through from a memory-side read port.

The response header is addressed back to the requester: the two IDs trade places, the tag is echoed and the priority is raised by one level. The payload length in bytes goes into a 9-bit field. A request that cannot be answered normally gets a header-only error response with no payload. This happens when the priority is already at its top value, or when the byte count is zero or larger than the block's maximum. The payload beats carry start, end and empty-byte markers. The block accepts the next request only after the header has been taken and every payload beat has been transferred.

Top module: `rd_resp_gen`

## Requirements
- R1: After reset `req_ready` is 1 and `hdr_valid` and `pl_valid` are 0. A request is accepted in a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 exactly when no response is in progress.
- R2: The response header has these fixed fields: bit 105 = 0, bit 104 = 0, bits [101:100] = 2'b01 (16-bit IDs), bits [99:96] = 4'b1101 (response class) and bits [47:0] = 0.
- R3: Header bits [95:80] hold the request's source ID, bits [79:64] hold the request's destination ID, and bits [55:48] hold the request's transaction tag.
- R4: For a request priority of 0, 1 or 2, header bits [103:102] hold the request priority plus one. For example, a request at 2'b01 is answered at 2'b10.
- R5: A normal response has bits [114:106] equal to the byte count, bits [63:60] = 4'b1000 (response with data) and bits [59:56] = 4'b0000 (done).
- R6: A request with priority 2'b11, or with a byte count of 0 or above 256, gets an error header: size 0, priority 2'b11, bits [63:60] = 4'b0000 and status 4'b0111. No payload beat is sent for it.
- R7: `hdr_valid` rises in the cycle after the request is accepted. It stays high, and `hdr_data` stays unchanged, until a cycle where `hdr_ready` is 1.
- R8: A normal response sends ceil(bytes/16) payload beats. A beat is offered (`pl_valid`) only when `rd_valid` is 1, and `pl_data` equals `rd_data` in that cycle. `rd_ready` is 1 only when a beat is still owed and `pl_ready` is 1.
- R9: `pl_sop` is 1 on the first beat of a response and on no other beat. `pl_eop` is 1 on the last beat and on no other beat.
- R10: `pl_empty` is 0 on every beat except the last. On the last beat it is 16 × beats − bytes. For example, a 32-byte read ends with empty 0 and a 17-byte read ends with empty 15.
- R11: The header and payload streams advance independently, in either order. Once the last beat has transferred, `pl_valid` stays 0 until a new request. The next request is accepted only after both streams have finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_src_id | input | 16 | ID of the requester |
| req_dst_id | input | 16 | ID of the target (this node) |
| req_prio | input | 2 | Request priority |
| req_tid | input | 8 | Transaction tag |
| req_bytes | input | 9 | Bytes requested |
| rd_valid | input | 1 | Memory-side read word available |
| rd_ready | output | 1 | Memory-side word consumed |
| rd_data | input | DATA_W | Memory-side read word |
| hdr_valid | output | 1 | Response header present |
| hdr_ready | input | 1 | Header consumer ready |
| hdr_data | output | 115 | Response header word |
| pl_valid | output | 1 | Payload beat present |
| pl_ready | input | 1 | Payload consumer ready |
| pl_data | output | DATA_W | Payload beat |
| pl_sop | output | 1 | First beat of the response |
| pl_eop | output | 1 | Last beat of the response |
| pl_empty | output | log2(DATA_W/8) | Unused bytes in the last beat |

## Verification
The bench covers byte counts of 1, 16, 17, 255 and 256, which cover single-beat reads, exact multiples and partial last beats. A wrong round-up would drop or add a beat, and a wrong empty count would show up on the last beat of a 17- or 255-byte read. It sends priority 3, a byte count of 0 and a byte count of 257, and expects header-only error responses. A design that still raised the priority or streamed data for these would wrap the priority to 0 or hold `rd_ready` high. It also throttles the two ready inputs separately, so that the header finishes before the payload in some responses and after it in others. A design that tied the streams together, or released `req_ready` early, would miss a beat or overwrite a header that has not yet been sent.

// File: rtl/rrg_pkg.sv
package rrg_pkg;

    localparam int ID_W   = 16;
    localparam int TAG_W  = 8;
    localparam int SIZE_W = 9;
    localparam int HDR_W  = 115;

    localparam logic [1:0] PRIO_TOP     = 2'b11;
    localparam logic [1:0] TT_ID16      = 2'b01;
    localparam logic [3:0] FTYPE_RESP   = 4'b1101;
    localparam logic [3:0] TTYPE_DATA   = 4'b1000;
    localparam logic [3:0] TTYPE_NODATA = 4'b0000;
    localparam logic [3:0] STAT_DONE    = 4'b0000;
    localparam logic [3:0] STAT_ERROR   = 4'b0111;

    // decoded read request
    typedef struct packed {
        logic [ID_W-1:0]   src;
        logic [ID_W-1:0]   dst;
        logic [1:0]        prio;
        logic [TAG_W-1:0]  tag;
        logic [SIZE_W-1:0] bytes;
    } rrg_req_t;

    // response header, MSB first; the packing order is the wire layout
    typedef struct packed {
        logic [SIZE_W-1:0] size;    // [114:106]
        logic              vc;      // [105]
        logic              crf;     // [104]
        logic [1:0]        prio;    // [103:102]
        logic [1:0]        tt;      // [101:100]
        logic [3:0]        ftype;   // [99:96]
        logic [ID_W-1:0]   dst;     // [95:80]
        logic [ID_W-1:0]   src;     // [79:64]
        logic [3:0]        ttype;   // [63:60]
        logic [3:0]        status;  // [59:56]
        logic [TAG_W-1:0]  tag;     // [55:48]
        logic [47:0]       rsvd;    // [47:0]
    } rrg_hdr_t;

endpackage

// File: rtl/rrg_len_calc.sv
module rrg_len_calc
    import rrg_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int MAX_BYTES = 256,
    localparam int BPB      = DATA_W / 8,
    localparam int EMPTY_W  = $clog2(BPB),
    localparam int BEAT_W   = $clog2(MAX_BYTES / BPB + 1)
) (
    input  logic [SIZE_W-1:0]  bytes,
    output logic [BEAT_W-1:0]  beats,
    output logic [EMPTY_W-1:0] last_empty,
    output logic               len_bad
);

    logic [SIZE_W:0] rounded;

    always_comb begin
        rounded    = {1'b0, bytes} + (SIZE_W + 1)'(BPB - 1);
        beats      = BEAT_W'(rounded >> EMPTY_W);
        last_empty = ~bytes[EMPTY_W-1:0] + EMPTY_W'(1);
        len_bad    = (bytes == '0) || (int'(bytes) > MAX_BYTES);
    end

endmodule

// File: rtl/rrg_hdr_build.sv
module rrg_hdr_build
    import rrg_pkg::*;
(
    input  rrg_req_t req,
    input  logic     len_bad,
    output rrg_hdr_t hdr,
    output logic     err
);

    always_comb begin
        err        = len_bad || (req.prio == PRIO_TOP);
        hdr        = '0;
        hdr.vc     = 1'b0;
        hdr.crf    = 1'b0;
        hdr.tt     = TT_ID16;
        hdr.ftype  = FTYPE_RESP;
        hdr.dst    = req.src;
        hdr.src    = req.dst;
        hdr.tag    = req.tag;
        if (err) begin
            hdr.size   = '0;
            hdr.prio   = PRIO_TOP;
            hdr.ttype  = TTYPE_NODATA;
            hdr.status = STAT_ERROR;
        end else begin
            hdr.size   = req.bytes;
            hdr.prio   = req.prio + 2'd1;
            hdr.ttype  = TTYPE_DATA;
            hdr.status = STAT_DONE;
        end
    end

endmodule

// File: rtl/rd_resp_gen.sv
module rd_resp_gen
    import rrg_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int MAX_BYTES = 256,
    localparam int BPB      = DATA_W / 8,
    localparam int EMPTY_W  = $clog2(BPB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [15:0]        req_src_id,
    input  logic [15:0]        req_dst_id,
    input  logic [1:0]         req_prio,
    input  logic [7:0]         req_tid,
    input  logic [8:0]         req_bytes,
    input  logic               rd_valid,
    output logic               rd_ready,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               hdr_valid,
    input  logic               hdr_ready,
    output logic [114:0]       hdr_data,
    output logic               pl_valid,
    input  logic               pl_ready,
    output logic [DATA_W-1:0]  pl_data,
    output logic               pl_sop,
    output logic               pl_eop,
    output logic [EMPTY_W-1:0] pl_empty
);

    localparam int BEAT_W = $clog2(MAX_BYTES / BPB + 1);

    typedef struct packed {
        logic               busy;
        logic               hdr_pend;
        logic               first;
        logic [BEAT_W-1:0]  left;
        logic [EMPTY_W-1:0] last_empty;
        rrg_hdr_t           hdr;
    } state_t;

    state_t state_d, state_q;

    rrg_req_t           req;
    rrg_hdr_t           new_hdr;
    logic               new_err;
    logic               len_bad;
    logic [BEAT_W-1:0]  new_beats;
    logic [EMPTY_W-1:0] new_empty;
    logic               owed;
    logic               take_req;
    logic               hdr_fire;
    logic               beat_fire;

    assign req = '{src: req_src_id, dst: req_dst_id, prio: req_prio,
                   tag: req_tid, bytes: req_bytes};

    rrg_len_calc #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) u_len (
        .bytes      (req_bytes),
        .beats      (new_beats),
        .last_empty (new_empty),
        .len_bad    (len_bad)
    );

    rrg_hdr_build u_hdr (
        .req     (req),
        .len_bad (len_bad),
        .hdr     (new_hdr),
        .err     (new_err)
    );

    // handshake terms
    assign owed      = state_q.busy && (state_q.left != '0);
    assign req_ready = !state_q.busy;
    assign take_req  = req_valid && req_ready;
    assign hdr_valid = state_q.hdr_pend;
    assign hdr_data  = state_q.hdr;
    assign hdr_fire  = hdr_valid && hdr_ready;
    assign pl_valid  = owed && rd_valid;
    assign rd_ready  = owed && pl_ready;
    assign beat_fire = pl_valid && pl_ready;
    assign pl_data   = rd_data;
    assign pl_sop    = state_q.first;
    assign pl_eop    = (state_q.left == BEAT_W'(1));
    assign pl_empty  = pl_eop ? state_q.last_empty : '0;

    always_comb begin
        state_d = state_q;
        if (take_req) begin
            state_d.busy       = 1'b1;
            state_d.hdr_pend   = 1'b1;
            state_d.first      = 1'b1;
            state_d.hdr        = new_hdr;
            state_d.left       = new_err ? '0 : new_beats;
            state_d.last_empty = new_err ? '0 : new_empty;
        end else if (state_q.busy) begin
            if (hdr_fire) begin
                state_d.hdr_pend = 1'b0;
            end
            if (beat_fire) begin
                state_d.left  = state_q.left - BEAT_W'(1);
                state_d.first = 1'b0;
            end
            if (!state_d.hdr_pend && (state_d.left == '0)) begin
                state_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/rrg_chk.sv
module rrg_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_ready,
    input logic [15:0]  req_src_id,
    input logic [15:0]  req_dst_id,
    input logic [1:0]   req_prio,
    input logic [7:0]   req_tid,
    input logic         rd_ready,
    input logic         hdr_valid,
    input logic         hdr_ready,
    input logic [114:0] hdr_data,
    input logic         pl_valid,
    input logic         pl_ready,
    input logic         pl_eop,
    input logic         pl_empty_zero
);

    // R1
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !req_ready);

    // R3
    ids_swapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (hdr_data[95:80] == $past(req_src_id))
            && (hdr_data[79:64] == $past(req_dst_id))
            && (hdr_data[55:48] == $past(req_tid)));

    // R4
    prio_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (hdr_data[59:56] != 4'b0000)
            || (hdr_data[103:102] == $past(req_prio) + 2'd1));

    // R6
    top_prio_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_prio == 2'b11) |=>
            (hdr_data[59:56] == 4'b0111) && (hdr_data[114:106] == 9'd0) && !pl_valid);

    // R7
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> hdr_valid && $stable(hdr_data));

    // R8
    rd_follows_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> pl_ready);

    // R10
    empty_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_eop) |-> pl_empty_zero);

    // R11
    quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_ready && pl_eop) |=> !pl_valid);

endmodule

bind rd_resp_gen rrg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_src_id    (req_src_id),
    .req_dst_id    (req_dst_id),
    .req_prio      (req_prio),
    .req_tid       (req_tid),
    .rd_ready      (rd_ready),
    .hdr_valid     (hdr_valid),
    .hdr_ready     (hdr_ready),
    .hdr_data      (hdr_data),
    .pl_valid      (pl_valid),
    .pl_ready      (pl_ready),
    .pl_eop        (pl_eop),
    .pl_empty_zero (pl_empty == '0)
);

// File: tb/sim_rd_resp_gen.sv
module sim_rd_resp_gen;

    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [15:0]   req_src_id = '0;
    logic [15:0]   req_dst_id = '0;
    logic [1:0]    req_prio = '0;
    logic [7:0]    req_tid = '0;
    logic [8:0]    req_bytes = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [DW-1:0] rd_data = '0;
    logic          hdr_valid;
    logic          hdr_ready = 1'b0;
    logic [114:0]  hdr_data;
    logic          pl_valid;
    logic          pl_ready = 1'b0;
    logic [DW-1:0] pl_data;
    logic          pl_sop;
    logic          pl_eop;
    logic [3:0]    pl_empty;

    always #5 clk = ~clk;

    rd_resp_gen u0 (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string rq, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [114:0] ref_hdr(input logic [15:0] s, input logic [15:0] d,
                                             input int p, input logic [7:0] t, input int n);
        logic [114:0] h;
        bit e;
        e = (p == 3) || (n == 0) || (n > 256);
        h = '0;
        h[114:106] = e ? 9'd0 : 9'(n);
        h[103:102] = e ? 2'd3 : 2'(p + 1);
        h[101:100] = 2'b01;
        h[99:96]   = 4'b1101;
        h[95:80]   = s;
        h[79:64]   = d;
        h[63:60]   = e ? 4'b0000 : 4'b1000;
        h[59:56]   = e ? 4'b0111 : 4'b0000;
        h[55:48]   = t;
        return h;
    endfunction

    int d_prio [12] = '{1, 0, 2, 3, 1, 1, 1, 1, 0, 2, 1, 1};
    int d_bytes[12] = '{32, 1, 16, 32, 17, 256, 255, 0, 257, 48, 8, 33};

    bit           m_busy = 0;
    bit           m_pend = 0;
    logic [114:0] m_hdr = '0;
    int           m_total = 0;
    int           m_sent = 0;
    int           m_bytes = 0;
    int           didx = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", 128'(req_ready), 128'd1);
        check(hdr_valid == 1'b0, "R1", 128'(hdr_valid), 128'd0);
        check(pl_valid == 1'b0, "R1", 128'(pl_valid), 128'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 8000; cyc++) begin
            int  pr;
            bit  want;
            bit  lastb;
            @(negedge clk);
            case (cyc / 2000)
                0:       pr = 100;
                1:       pr = 50;
                2:       pr = 85;
                default: pr = 30;
            endcase
            if (didx < 12) begin
                req_prio  = 2'(d_prio[didx]);
                req_bytes = 9'(d_bytes[didx]);
            end else begin
                req_prio  = 2'($urandom % 4);
                req_bytes = ($urandom % 8 == 0) ? 9'($urandom % 512) : 9'(1 + $urandom % 256);
            end
            req_src_id = 16'($urandom);
            req_dst_id = 16'($urandom);
            req_tid    = 8'($urandom);
            req_valid  = ($urandom % 100) < 70;
            hdr_ready  = ($urandom % 100) < pr;
            pl_ready   = ($urandom % 100) < ((cyc % 700 < 350) ? pr : 100 - pr / 2);
            rd_valid   = ($urandom % 100) < 80;
            rd_data    = {$urandom, $urandom, $urandom, $urandom};
            #1;
            // R11 holds requests off while busy; R1 when idle
            check(req_ready == !m_busy, m_busy ? "R11" : "R1", 128'(req_ready), 128'(!m_busy));
            check(hdr_valid == m_pend, "R7", 128'(hdr_valid), 128'(m_pend));
            if (m_pend && hdr_valid) begin
                check(hdr_data[95:80] == m_hdr[95:80] && hdr_data[79:64] == m_hdr[79:64]
                      && hdr_data[55:48] == m_hdr[55:48], "R3", 128'(hdr_data), 128'(m_hdr));
                check(hdr_data[103:102] == m_hdr[103:102], "R4",
                      128'(hdr_data[103:102]), 128'(m_hdr[103:102]));
                check(hdr_data[114:106] == m_hdr[114:106] && hdr_data[63:56] == m_hdr[63:56],
                      (m_hdr[59:56] == 4'b0111) ? "R6" : "R5",
                      128'(hdr_data[114:56]), 128'(m_hdr[114:56]));
                check(hdr_data[105:96] == m_hdr[105:96] && hdr_data[47:0] == 48'd0, "R2",
                      128'(hdr_data), 128'(m_hdr));
            end
            want = m_busy && (m_sent < m_total);
            check(pl_valid == (want && rd_valid), "R8", 128'(pl_valid), 128'(want && rd_valid));
            check(rd_ready == (want && pl_ready), "R8", 128'(rd_ready), 128'(want && pl_ready));
            if (want && pl_valid) begin
                lastb = (m_sent == m_total - 1);
                check(pl_data == rd_data, "R8", pl_data, rd_data);
                check(pl_sop == (m_sent == 0), "R9", 128'(pl_sop), 128'(m_sent == 0));
                check(pl_eop == lastb, "R9", 128'(pl_eop), 128'(lastb));
                check(int'(pl_empty) == (lastb ? m_total * 16 - m_bytes : 0), "R10",
                      128'(pl_empty), 128'(lastb ? m_total * 16 - m_bytes : 0));
            end
            // reference model step
            if (!m_busy) begin
                if (req_valid) begin
                    int n;
                    n       = int'(req_bytes);
                    m_busy  = 1;
                    m_pend  = 1;
                    m_hdr   = ref_hdr(req_src_id, req_dst_id, int'(req_prio), req_tid, n);
                    m_bytes = n;
                    m_sent  = 0;
                    m_total = (req_prio == 2'd3 || n == 0 || n > 256) ? 0 : (n + 15) / 16;
                    didx++;
                end
            end else begin
                if (m_pend && hdr_ready) m_pend = 0;
                if (want && rd_valid && pl_ready) m_sent++;
                if (!m_pend && m_sent == m_total) m_busy = 0;
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule